// File: doc/BRIEF.md
# Parallel I/O Port Pin Multiplexer

This block owns a bank of external pins, 32 by default. Five per-pin control registers sit behind a small memory-mapped register bus. They set, for every pin, whether it is a general-purpose I/O or belongs to one of two dedicated peripheral functions, which way it points, whether it only pulls low, and which level it drives as a plain output. The block turns these settings into an output value and an output enable for each pad. It also steers the synchronized pad level to whichever peripheral input owns the pin.

A peripheral input whose pin is not assigned to it sees a fixed level set per input by a parameter, so an idle request line can read low and an idle completion line can read high. Software reads the data register to see either the value it last wrote (output pins) or the synchronized pad level (input pins).

Top module: `pio_port_mux`

## Requirements
- R1: After reset every control register reads 0. Every pin is then a general-purpose input with `pin_oe` low and `pin_out` low, and each peripheral input shows its default level.
- R2: Register index on `bus_addr`: 0 = pin assignment, 1 = option select, 2 = direction, 3 = open drain, 4 = data. A write with `bus_wr` high updates only the byte lanes whose `bus_be` bit is set (lane k covers bits 8k+7..8k). It takes effect at that clock edge, and `bus_rdata` shows the new value from the following cycle.
- R3: For a general-purpose pin (assignment bit 0) without open drain, `pin_out` equals the data register bit and `pin_oe` equals the direction bit.
- R4: For a dedicated pin (assignment bit 1) without open drain, `pin_out` follows `alt1_tx` when the option bit is 0 and `alt2_tx` when it is 1.
- R5: For a pin whose open-drain bit is 1, `pin_out` is 0. `pin_oe` is 1 only when the pin would otherwise drive and its value is 0.
- R6: `alt1_rx[i]` carries the synchronized level of pin i when assignment is 1 and option is 0, and otherwise carries `ALT1_DEFAULT[i]`. `alt2_rx[i]` does the same for assignment 1 and option 1, with `ALT2_DEFAULT[i]`.
- R7: A read of the data register returns the stored data bit for pins whose direction bit is 1, and the synchronized pad level for pins whose direction bit is 0.
- R8: A change on `pin_in` reaches `alt*_rx` and the data readback after exactly two rising clock edges.
- R9: Register indices 5 to 7 read as 0, and a write to them changes no register.
- R10: A dedicated pin may drive when its direction bit or its open-drain bit is 1. This makes a bidirectional dedicated signal: direction 0 with open drain 1. A general-purpose pin may drive only when its direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | PIN_COUNT | Write data |
| bus_be | input | PIN_COUNT/8 | Byte-lane write enables |
| bus_rdata | output | PIN_COUNT | Read data of the indexed register |
| pin_in | input | PIN_COUNT | Pad input levels (asynchronous) |
| pin_out | output | PIN_COUNT | Pad output values |
| pin_oe | output | PIN_COUNT | Pad output enables |
| alt1_tx | input | PIN_COUNT | Values driven by dedicated function 1 |
| alt2_tx | input | PIN_COUNT | Values driven by dedicated function 2 |
| alt1_rx | output | PIN_COUNT | Inputs seen by dedicated function 1 |
| alt2_rx | output | PIN_COUNT | Inputs seen by dedicated function 2 |

## Verification
The bench builds the port with PIN_COUNT = 16. That gives two byte lanes, so a partial strobe can be shown to leave one half of a register alone. The default levels are 16'h00F0 for function 1 and 16'hA5A5 for function 2. These are uneven patterns, so a pin that is routed can be told apart from one that shows its default in both directions of every bit. Each vector in the table mixes general-purpose, dedicated and open-drain pins across the two bytes. A single comparison therefore covers several requirements at once.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_ASSIGN = 3'd0,
        REG_OPTION = 3'd1,
        REG_DIR    = 3'd2,
        REG_ODRAIN = 3'd3,
        REG_DATA   = 3'd4
    } pio_reg_e;

endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [REG_IDX_W-1:0]   addr,
    input  logic [PIN_COUNT-1:0]   wdata,
    input  logic [PIN_COUNT/8-1:0] be,
    output logic [PIN_COUNT-1:0]   asg,
    output logic [PIN_COUNT-1:0]   opt,
    output logic [PIN_COUNT-1:0]   dir,
    output logic [PIN_COUNT-1:0]   od,
    output logic [PIN_COUNT-1:0]   dat
);
    localparam int LANES = PIN_COUNT / 8;

    typedef struct packed {
        logic [PIN_COUNT-1:0] asg;
        logic [PIN_COUNT-1:0] opt;
        logic [PIN_COUNT-1:0] dir;
        logic [PIN_COUNT-1:0] od;
        logic [PIN_COUNT-1:0] dat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [PIN_COUNT-1:0] lane_mask;

    // expand byte enables to a bit mask
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{be[b]}};
    end

    function automatic logic [PIN_COUNT-1:0] merge(
        input logic [PIN_COUNT-1:0] old_v,
        input logic [PIN_COUNT-1:0] new_v,
        input logic [PIN_COUNT-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            case (addr)
                REG_ASSIGN: ctl_d.asg = merge(ctl_q.asg, wdata, lane_mask);
                REG_OPTION: ctl_d.opt = merge(ctl_q.opt, wdata, lane_mask);
                REG_DIR:    ctl_d.dir = merge(ctl_q.dir, wdata, lane_mask);
                REG_ODRAIN: ctl_d.od  = merge(ctl_q.od,  wdata, lane_mask);
                REG_DATA:   ctl_d.dat = merge(ctl_q.dat, wdata, lane_mask);
                default:    ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign asg = ctl_q.asg;
    assign opt = ctl_q.opt;
    assign dir = ctl_q.dir;
    assign od  = ctl_q.od;
    assign dat = ctl_q.dat;

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.stage1 = async_in;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q.stage2;

endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell #(
    parameter logic ALT1_DEF = 1'b0,
    parameter logic ALT2_DEF = 1'b0
) (
    input  logic asg,
    input  logic opt,
    input  logic dir,
    input  logic od,
    input  logic dat,
    input  logic pad_sync,
    input  logic alt1_tx,
    input  logic alt2_tx,
    output logic pad_out,
    output logic pad_oe,
    output logic alt1_rx,
    output logic alt2_rx,
    output logic rd_bit
);
    logic drive_val;
    logic drive_en;

    always_comb begin
        // source selection: GPIO data or one of two dedicated functions
        if (asg) begin
            drive_val = opt ? alt2_tx : alt1_tx;
            drive_en  = dir | od;
        end else begin
            drive_val = dat;
            drive_en  = dir;
        end

        // open drain: pull low only, release otherwise
        if (od) begin
            pad_out = 1'b0;
            pad_oe  = drive_en & ~drive_val;
        end else begin
            pad_out = drive_val;
            pad_oe  = drive_en;
        end

        alt1_rx = (asg && !opt) ? pad_sync : ALT1_DEF;
        alt2_rx = (asg && opt)  ? pad_sync : ALT2_DEF;
        rd_bit  = dir ? dat : pad_sync;
    end

endmodule

// File: rtl/pio_port_mux.sv
module pio_port_mux
    import pio_pkg::*;
#(
    parameter int                   PIN_COUNT    = 32,
    parameter logic [PIN_COUNT-1:0] ALT1_DEFAULT = '0,
    parameter logic [PIN_COUNT-1:0] ALT2_DEFAULT = '1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [REG_IDX_W-1:0]   bus_addr,
    input  logic [PIN_COUNT-1:0]   bus_wdata,
    input  logic [PIN_COUNT/8-1:0] bus_be,
    output logic [PIN_COUNT-1:0]   bus_rdata,
    input  logic [PIN_COUNT-1:0]   pin_in,
    output logic [PIN_COUNT-1:0]   pin_out,
    output logic [PIN_COUNT-1:0]   pin_oe,
    input  logic [PIN_COUNT-1:0]   alt1_tx,
    input  logic [PIN_COUNT-1:0]   alt2_tx,
    output logic [PIN_COUNT-1:0]   alt1_rx,
    output logic [PIN_COUNT-1:0]   alt2_rx
);
    logic [PIN_COUNT-1:0] asg_q, opt_q, dir_q, od_q, dat_q;
    logic [PIN_COUNT-1:0] pad_sync;
    logic [PIN_COUNT-1:0] data_view;

    pio_regfile #(.PIN_COUNT(PIN_COUNT)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .be    (bus_be),
        .asg   (asg_q),
        .opt   (opt_q),
        .dir   (dir_q),
        .od    (od_q),
        .dat   (dat_q)
    );

    pio_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pad_sync)
    );

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        pio_pin_cell #(
            .ALT1_DEF (ALT1_DEFAULT[i]),
            .ALT2_DEF (ALT2_DEFAULT[i])
        ) u_cell (
            .asg      (asg_q[i]),
            .opt      (opt_q[i]),
            .dir      (dir_q[i]),
            .od       (od_q[i]),
            .dat      (dat_q[i]),
            .pad_sync (pad_sync[i]),
            .alt1_tx  (alt1_tx[i]),
            .alt2_tx  (alt2_tx[i]),
            .pad_out  (pin_out[i]),
            .pad_oe   (pin_oe[i]),
            .alt1_rx  (alt1_rx[i]),
            .alt2_rx  (alt2_rx[i]),
            .rd_bit   (data_view[i])
        );
    end

    always_comb begin
        case (bus_addr)
            REG_ASSIGN: bus_rdata = asg_q;
            REG_OPTION: bus_rdata = opt_q;
            REG_DIR:    bus_rdata = dir_q;
            REG_ODRAIN: bus_rdata = od_q;
            REG_DATA:   bus_rdata = data_view;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_port_mux_checks.sv
module pio_port_mux_checks
    import pio_pkg::*;
#(
    parameter int                   PIN_COUNT    = 32,
    parameter logic [PIN_COUNT-1:0] ALT1_DEFAULT = '0,
    parameter logic [PIN_COUNT-1:0] ALT2_DEFAULT = '1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic [REG_IDX_W-1:0]   bus_addr,
    input logic [PIN_COUNT-1:0]   bus_wdata,
    input logic [PIN_COUNT/8-1:0] bus_be,
    input logic [PIN_COUNT-1:0]   pin_in,
    input logic [PIN_COUNT-1:0]   pin_out,
    input logic [PIN_COUNT-1:0]   pin_oe,
    input logic [PIN_COUNT-1:0]   alt1_rx,
    input logic [PIN_COUNT-1:0]   alt2_rx,
    input logic [PIN_COUNT-1:0]   asg_q,
    input logic [PIN_COUNT-1:0]   opt_q,
    input logic [PIN_COUNT-1:0]   dir_q,
    input logic [PIN_COUNT-1:0]   od_q
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R1: first cycle out of reset, nothing is driven
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd0) |-> (pin_oe == '0));

    // R2: a full-strobe direction write lands on the next edge
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR && (&bus_be)) |=> (dir_q == $past(bus_wdata)));

    // R5: open-drain pins never drive high
    assert_od_low_only_R5: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & od_q) == '0));

    // R10: no drive without direction or open drain
    assert_no_stray_drive_R10: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~(dir_q | od_q)) == '0));

    // R6: unrouted peripheral inputs sit at their default level
    assert_alt_defaults_R6: assert property (@(posedge clk) disable iff (rst)
        ((((alt1_rx ^ ALT1_DEFAULT) & ~(asg_q & ~opt_q)) == '0) &&
         (((alt2_rx ^ ALT2_DEFAULT) & ~(asg_q & opt_q)) == '0)));

    // R8: routed input equals the pad level two edges earlier
    assert_sync_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (((alt1_rx ^ $past(pin_in, 2)) & asg_q & ~opt_q) == '0));

endmodule

bind pio_port_mux pio_port_mux_checks #(
    .PIN_COUNT    (PIN_COUNT),
    .ALT1_DEFAULT (ALT1_DEFAULT),
    .ALT2_DEFAULT (ALT2_DEFAULT)
) u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .alt1_rx   (alt1_rx),
    .alt2_rx   (alt2_rx),
    .asg_q     (asg_q),
    .opt_q     (opt_q),
    .dir_q     (dir_q),
    .od_q      (od_q)
);

// File: tb/pio_port_mux_test.sv
module pio_port_mux_test;
    import pio_pkg::*;

    localparam int          N  = 16;
    localparam logic [15:0] D1 = 16'h00F0;
    localparam logic [15:0] D2 = 16'hA5A5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N/8-1:0] bus_be = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic [N-1:0]  alt1_tx = '0, alt2_tx = '0;
    logic [N-1:0]  alt1_rx, alt2_rx;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pio_port_mux #(
        .PIN_COUNT    (N),
        .ALT1_DEFAULT (D1),
        .ALT2_DEFAULT (D2)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .alt1_tx   (alt1_tx),
        .alt2_tx   (alt2_tx),
        .alt1_rx   (alt1_rx),
        .alt2_rx   (alt2_rx)
    );

    typedef struct packed {
        logic [15:0] asg, opt, dir, od, dat, pin, a1, a2;
        logic [15:0] x_out, x_oe, x_r1, x_r2, x_rd;
    } vec_t;

    // asg opt dir od dat pin a1tx a2tx | out oe a1rx a2rx rd
    localparam vec_t VECS [4] = '{
        '{16'h0000, 16'h0000, 16'hFF00, 16'h0000, 16'h1234, 16'hABCD, 16'h0000, 16'h0000,
          16'h1234, 16'hFF00, 16'h00F0, 16'hA5A5, 16'h12CD},
        '{16'hFFFF, 16'hFF00, 16'h0F0F, 16'h0000, 16'h0000, 16'h5A3C, 16'hC3C3, 16'h6699,
          16'h66C3, 16'h0F0F, 16'h003C, 16'h5AA5, 16'h5030},
        '{16'h00FF, 16'h0000, 16'h0000, 16'hFFFF, 16'h0F0F, 16'hFFFF, 16'h3355, 16'h0000,
          16'h0000, 16'h00AA, 16'h00FF, 16'hA5A5, 16'hFFFF},
        '{16'h0000, 16'h0000, 16'hFFFF, 16'hF0F0, 16'h3C3C, 16'h0000, 16'hFFFF, 16'hFFFF,
          16'h0C0C, 16'hCFCF, 16'h00F0, 16'hA5A5, 16'h3C3C}
    };

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d, input logic [N/8-1:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int r = 0; r < 4; r++) begin
            rd(3'(r), v);
            check("R1", "control reg after reset", v, '0);
        end
        check("R1", "pin_oe", pin_oe, '0);
        check("R1", "pin_out", pin_out, '0);
        check("R1", "alt1_rx default", alt1_rx, D1);
        check("R1", "alt2_rx default", alt2_rx, D2);

        // vector table: R3 R4 R5 R6 R7 R10
        for (int k = 0; k < 4; k++) begin
            wr(REG_ASSIGN, VECS[k].asg, '1);
            wr(REG_OPTION, VECS[k].opt, '1);
            wr(REG_DIR,    VECS[k].dir, '1);
            wr(REG_ODRAIN, VECS[k].od,  '1);
            wr(REG_DATA,   VECS[k].dat, '1);
            pin_in  = VECS[k].pin;
            alt1_tx = VECS[k].a1;
            alt2_tx = VECS[k].a2;
            repeat (3) @(negedge clk);
            check("R3/R4/R5", "pin_out", pin_out, VECS[k].x_out);
            check("R5/R10", "pin_oe", pin_oe, VECS[k].x_oe);
            check("R6", "alt1_rx", alt1_rx, VECS[k].x_r1);
            check("R6", "alt2_rx", alt2_rx, VECS[k].x_r2);
            rd(REG_DATA, v);
            check("R7", "data readback", v, VECS[k].x_rd);
        end

        // R2: readback and partial byte strobe
        wr(REG_OPTION, 16'hBEEF, '1);
        rd(REG_OPTION, v);
        check("R2", "option readback", v, 16'hBEEF);
        wr(REG_DIR, 16'h0000, '1);
        wr(REG_DIR, 16'hFFFF, 2'b01);
        rd(REG_DIR, v);
        check("R2", "low lane only", v, 16'h00FF);
        wr(REG_DIR, 16'h1200, 2'b10);
        rd(REG_DIR, v);
        check("R2", "high lane only", v, 16'h12FF);

        // R9: unmapped index ignored on write and reads zero
        wr(3'd7, 16'hFFFF, '1);
        rd(3'd7, v);
        check("R9", "unmapped read", v, '0);
        rd(REG_OPTION, v);
        check("R9", "option untouched", v, 16'hBEEF);
        rd(REG_DIR, v);
        check("R9", "dir untouched", v, 16'h12FF);

        // R8: two-edge synchronizer latency on readback
        wr(REG_DIR, 16'h0000, '1);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        pin_in = 16'h9C63;
        @(negedge clk);
        rd(REG_DATA, v);
        check("R8", "after one edge", v, 16'h0000);
        @(negedge clk);
        rd(REG_DATA, v);
        check("R8", "after two edges", v, 16'h9C63);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule